// File: doc/BRIEF.md
# Seven-Register Bus Datapath

This block is a small processor datapath made of seven general registers, two source selectors and one shared ALU. Each clock cycle, a 14-bit control word does four things. It chooses the operand for the A bus and the operand for the B bus. It chooses the ALU operation. It chooses which register, if any, captures the result on the next rising clock edge.

Either bus can take its operand from an external data input instead of a register. The ALU result is always visible on the external data output, so a control word can move data through the block without writing any register. A carry flag and a zero flag describe the result that is on the output in the current cycle. The block is driven by an outside sequencer that presents one control word per cycle.

Top module: `regbus_dp`

## Requirements
- R1: An active-low reset clears all seven registers to zero, whenever it is asserted.
- R2: The control word is laid out as follows. A-bus select is in bits [13:11], B-bus select in [10:8], destination select in [7:5] and operation code in [4:0]. For example, 14'b010_011_001_00101 computes R1 = R2 - R3.
- R3: A source select of 0 places ext_in on that bus. A source select of k (1 to 7) places register Rk on that bus.
- R4: A destination select of k (1 to 7) loads Rk with the ext_out value of that cycle at the next rising clock edge. No other register changes, so at most one register is written per clock.
- R5: A destination select of 0 writes no register, while ext_out still shows the ALU result.
- R6: Arithmetic operations are all modulo 2^DATA_W. Code 00000 passes A. Code 00001 gives A+1. Code 00010 gives A+B. Code 00101 gives A-B. Code 00110 gives A-1.
- R7: Logic operations: code 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, and 01110 gives NOT A.
- R8: Code 10000 shifts A right by one place with a zero entering at the top, and carry_out takes the old A[0]. Code 11000 shifts A left by one place with a zero entering at the bottom, and carry_out takes the old A[DATA_W-1].
- R9: carry_out for the arithmetic codes:
  - add: the carry out of the sum;
  - subtract: 1 when A >= B (unsigned);
  - increment: 1 when A is all ones;
  - decrement: 1 when A is not zero;
  - pass and logic codes: 0.
- R10: Every operation code not listed in R6 to R8 gives result 0 and carry 0.
- R11: zero_out is 1 exactly when the ALU result is 0.
- R12: A register used as both source and destination in one control word supplies its old value to the ALU. It holds the result after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 14 | Source, destination and operation selects for this cycle |
| ext_in | input | DATA_W | External operand, selected by source code 0 |
| ext_out | output | DATA_W | ALU result of the current control word |
| carry_out | output | 1 | Carry of the current result |
| zero_out | output | 1 | High when the current result is zero |

## Verification
Two functions can fall in the same cycle: a register is read onto a bus and written as the destination in the same control word. The bench provokes this with words whose destination equals the A source, or both sources, for add and increment. It checks ext_out before the edge against the old contents. It then reads the register back after the edge and expects the new value. A second overlap is tested separately: an external operand feeds an ALU operation while a register is also loaded in that cycle.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

   localparam int SEL_W = 3;
   localparam int OPR_W = 5;
   localparam int NREG  = (1 << SEL_W) - 1;
   localparam int CW_W  = 3 * SEL_W + OPR_W;

   localparam logic [OPR_W-1:0] OP_PASS = 5'b00000;
   localparam logic [OPR_W-1:0] OP_INC  = 5'b00001;
   localparam logic [OPR_W-1:0] OP_ADD  = 5'b00010;
   localparam logic [OPR_W-1:0] OP_SUB  = 5'b00101;
   localparam logic [OPR_W-1:0] OP_DEC  = 5'b00110;
   localparam logic [OPR_W-1:0] OP_AND  = 5'b01000;
   localparam logic [OPR_W-1:0] OP_OR   = 5'b01010;
   localparam logic [OPR_W-1:0] OP_XOR  = 5'b01100;
   localparam logic [OPR_W-1:0] OP_NOT  = 5'b01110;
   localparam logic [OPR_W-1:0] OP_SHR  = 5'b10000;
   localparam logic [OPR_W-1:0] OP_SHL  = 5'b11000;

   typedef struct packed {
      logic [SEL_W-1:0] src_a;
      logic [SEL_W-1:0] src_b;
      logic [SEL_W-1:0] dst;
      logic [OPR_W-1:0] op;
   } ctrl_t;

endpackage

// File: rtl/regbus_src_mux.sv
module regbus_src_mux #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic [(1<<SEL_W)-1:0][DATA_W-1:0] src_vec,
   input  logic [SEL_W-1:0]                  sel,
   output logic [DATA_W-1:0]                 bus
);
   // index 0 carries the external operand, index k carries Rk
   assign bus = src_vec[sel];
endmodule

// File: rtl/regbus_dst_dec.sv
module regbus_dst_dec #(
   parameter int SEL_W = 3,
   localparam int NREG = (1 << SEL_W) - 1
) (
   input  logic [SEL_W-1:0] sel,
   output logic [NREG-1:0]  load_en
);
   // code 0 decodes to no enable at all
   for (genvar k = 1; k <= NREG; k++) begin : g_dec
      assign load_en[k-1] = (sel == SEL_W'(k));
   end
endmodule

// File: rtl/regbus_bank.sv
module regbus_bank #(
   parameter int DATA_W = 8,
   parameter int NREG   = 7
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NREG-1:0]             load_en,
   input  logic [DATA_W-1:0]           wdata,
   output logic [NREG-1:0][DATA_W-1:0] regs_q
);

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[k] <= '0;
         else if (load_en[k])
            regs_q[k] <= wdata;
      end

      // R4
      load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
         load_en[k] |=> (regs_q[k] == $past(wdata)));
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (regs_q == '0));

   // R4
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_en));

   // R5
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en == '0) |=> $stable(regs_q));

endmodule

// File: rtl/regbus_alu.sv
module regbus_alu
   import regbus_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [OPR_W-1:0]  op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic              cout,
   output logic              zero
);
   localparam logic [DATA_W-1:0] ONES = '1;

   logic [DATA_W:0] arith;   // {carry, sum}

   if (SHARED_ADDER) begin : g_shared
      logic [DATA_W-1:0] opnd;
      logic              cin;
      always_comb begin
         opnd = '0;
         cin  = 1'b0;
         case (op)
            OP_INC:  cin = 1'b1;
            OP_ADD:  opnd = b;
            OP_SUB:  begin opnd = ~b; cin = 1'b1; end
            OP_DEC:  opnd = ONES;
            default: ;
         endcase
         arith = {1'b0, a} + {1'b0, opnd} + {{DATA_W{1'b0}}, cin};
      end
   end else begin : g_split
      logic [DATA_W:0] s_inc, s_add, s_sub, s_dec;
      assign s_inc = {1'b0, a} + {{DATA_W{1'b0}}, 1'b1};
      assign s_add = {1'b0, a} + {1'b0, b};
      assign s_sub = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, 1'b1};
      assign s_dec = {1'b0, a} + {1'b0, ONES};
      always_comb begin
         case (op)
            OP_INC:  arith = s_inc;
            OP_ADD:  arith = s_add;
            OP_SUB:  arith = s_sub;
            OP_DEC:  arith = s_dec;
            default: arith = '0;
         endcase
      end
   end

   always_comb begin
      res  = '0;
      cout = 1'b0;
      case (op)
         OP_PASS: res = a;
         OP_INC, OP_ADD, OP_SUB, OP_DEC: {cout, res} = arith;
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_NOT:  res = ~a;
         OP_SHR:  begin res = {1'b0, a[DATA_W-1:1]}; cout = a[0]; end
         OP_SHL:  begin res = {a[DATA_W-2:0], 1'b0}; cout = a[DATA_W-1]; end
         default: ;
      endcase
   end

   assign zero = (res == '0);

endmodule

// File: rtl/regbus_dp.sv
module regbus_dp
   import regbus_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW_W-1:0]   ctrl_word,
   input  logic [DATA_W-1:0] ext_in,
   output logic [DATA_W-1:0] ext_out,
   output logic              carry_out,
   output logic              zero_out
);

   if (DATA_W < 2 || DATA_W > 64) begin : g_bad_width
      $error("regbus_dp: DATA_W must lie in 2..64");
   end
   if ($bits(ctrl_t) != CW_W) begin : g_bad_cw
      $error("regbus_dp: control word layout mismatch");
   end

   ctrl_t                             cw;
   logic [NREG-1:0][DATA_W-1:0]       regs_q;
   logic [(1<<SEL_W)-1:0][DATA_W-1:0] src_vec;
   logic [DATA_W-1:0]                 a_bus, b_bus, alu_res;
   logic [NREG-1:0]                   load_en;
   logic                              alu_c, alu_z;

   assign cw      = ctrl_t'(ctrl_word);
   assign src_vec = {regs_q, ext_in};

   regbus_src_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) a_mux_i (
      .src_vec(src_vec), .sel(cw.src_a), .bus(a_bus));

   regbus_src_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) b_mux_i (
      .src_vec(src_vec), .sel(cw.src_b), .bus(b_bus));

   regbus_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) alu_i (
      .op(cw.op), .a(a_bus), .b(b_bus),
      .res(alu_res), .cout(alu_c), .zero(alu_z));

   regbus_dst_dec #(.SEL_W(SEL_W)) dec_i (
      .sel(cw.dst), .load_en(load_en));

   regbus_bank #(.DATA_W(DATA_W), .NREG(NREG)) bank_i (
      .clk(clk), .rst_n(rst_n), .load_en(load_en),
      .wdata(alu_res), .regs_q(regs_q));

   assign ext_out   = alu_res;
   assign carry_out = alu_c;
   assign zero_out  = alu_z;

   // R3
   ext_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw.src_a == '0) |-> (a_bus == ext_in));

   // R9
   sub_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw.op == OP_SUB && a_bus == b_bus) |-> (zero_out && carry_out));

   // R6
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw.op == OP_PASS) |-> (ext_out == a_bus && !carry_out));

   // R5
   no_dest_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw.dst == '0 && cw.op == OP_NOT) |-> (ext_out == ~a_bus));

endmodule

// File: tb/regbus_dp_tb_top.sv
module regbus_dp_tb_top;
   localparam int CLK_P = 10;
   localparam int W     = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [13:0]  ctrl_word = '0;
   logic [W-1:0] ext_in = '0;
   logic [W-1:0] ext_out;
   logic         carry_out, zero_out;

   int n_chk = 0;
   int n_err = 0;
   logic [W-1:0] mdl [1:7];

   regbus_dp #(.DATA_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ext_in(ext_in),
      .ext_out(ext_out), .carry_out(carry_out), .zero_out(zero_out));

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected {carry, result} from the operation table of the requirements
   function automatic logic [W:0] ref_alu(input logic [4:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W:0] r;
      case (op)
         5'b00000: r = {1'b0, a};
         5'b00001: r = {(a == 8'hFF), W'(a + 8'd1)};
         5'b00010: r = {1'b0, a} + {1'b0, b};
         5'b00101: r = {(a >= b), W'(a - b)};
         5'b00110: r = {(a != 8'h00), W'(a - 8'd1)};
         5'b01000: r = {1'b0, a & b};
         5'b01010: r = {1'b0, a | b};
         5'b01100: r = {1'b0, a ^ b};
         5'b01110: r = {1'b0, ~a};
         5'b10000: r = {a[0], 1'b0, a[W-1:1]};
         5'b11000: r = {a[W-1], a[W-2:0], 1'b0};
         default:  r = '0;
      endcase
      return r;
   endfunction

   function automatic logic [W-1:0] src_val(input logic [2:0] s, input logic [W-1:0] ein);
      return (s == 3'd0) ? ein : mdl[s];
   endfunction

   task automatic step(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                       input logic [4:0] op, input logic [W-1:0] ein, input string tag);
      logic [W:0] e;
      @(negedge clk);
      ctrl_word = {sa, sb, sd, op};
      ext_in    = ein;
      #1;
      e = ref_alu(op, src_val(sa, ein), src_val(sb, ein));
      chk({tag, " result"}, 32'(ext_out), 32'(e[W-1:0]));
      chk({tag, " carry"},  32'(carry_out), 32'(e[W]));
      chk({tag, " zero"},   32'(zero_out), 32'(e[W-1:0] == '0));
      @(posedge clk);
      if (sd != 3'd0) mdl[sd] = e[W-1:0];
   endtask

   task automatic read_all(input string tag);
      for (int k = 1; k <= 7; k++) step(3'(k), 3'd0, 3'd0, 5'b00000, 8'h00, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 1; k <= 7; k++) mdl[k] = '0;
   endtask

   task automatic t_load();
      logic [W-1:0] v [1:7];
      v = '{8'h12, 8'h5A, 8'h3C, 8'hFF, 8'h00, 8'h80, 8'h01};
      for (int k = 1; k <= 7; k++) step(3'd0, 3'd0, 3'(k), 5'b00000, v[k], "R3 R4 ext load");
      read_all("R4 readback");
      chk("R4 R2 held", 32'(mdl[2]), 32'h5A);
   endtask

   task automatic t_arith();
      step(3'd2, 3'd3, 3'd0, 5'b00010, 8'h00, "R6 add");
      step(3'd4, 3'd7, 3'd0, 5'b00010, 8'h00, "R9 add carry");
      step(3'd2, 3'd3, 3'd0, 5'b00101, 8'h00, "R9 sub no borrow");
      step(3'd3, 3'd2, 3'd0, 5'b00101, 8'h00, "R9 sub borrow");
      step(3'd4, 3'd0, 3'd0, 5'b00001, 8'h00, "R9 inc wrap");
      step(3'd5, 3'd0, 3'd0, 5'b00110, 8'h00, "R9 dec wrap");
      step(3'd7, 3'd0, 3'd0, 5'b00110, 8'h00, "R11 dec to zero");
      step(3'd0, 3'd1, 3'd0, 5'b00101, 8'h12, "R11 sub equal");
   endtask

   task automatic t_logic();
      step(3'd2, 3'd3, 3'd0, 5'b01000, 8'h00, "R7 and");
      step(3'd2, 3'd3, 3'd0, 5'b01010, 8'h00, "R7 or");
      step(3'd2, 3'd3, 3'd0, 5'b01100, 8'h00, "R7 xor");
      step(3'd4, 3'd0, 3'd0, 5'b01110, 8'h00, "R7 not");
      step(3'd0, 3'd4, 3'd0, 5'b01000, 8'hA5, "R7 ext and");
   endtask

   task automatic t_shift();
      step(3'd7, 3'd0, 3'd0, 5'b10000, 8'h00, "R8 shr carry");
      step(3'd6, 3'd0, 3'd0, 5'b11000, 8'h00, "R8 shl carry");
      step(3'd0, 3'd0, 3'd0, 5'b10000, 8'h96, "R8 shr ext");
      step(3'd0, 3'd0, 3'd0, 5'b11000, 8'h41, "R8 shl ext");
   endtask

   task automatic t_undef();
      logic [4:0] codes [9];
      codes = '{5'b00011, 5'b00100, 5'b00111, 5'b01001, 5'b01011,
                5'b01101, 5'b01111, 5'b10001, 5'b11111};
      for (int i = 0; i < 9; i++) begin
         step(3'd0, 3'd0, 3'd6, 5'b01110, 8'h33, "R10 preload");
         step(3'd6, 3'd6, 3'd6, codes[i], 8'h00, "R10 undefined");
         step(3'd6, 3'd0, 3'd0, 5'b00000, 8'h00, "R10 zero written");
      end
   endtask

   task automatic t_nowrite();
      step(3'd1, 3'd2, 3'd0, 5'b01110, 8'h00, "R5 no dest out");
      step(3'd0, 3'd0, 3'd0, 5'b00000, 8'hC3, "R5 ext pass");
      read_all("R5 regs unchanged");
   endtask

   task automatic t_same_reg();
      step(3'd3, 3'd3, 3'd3, 5'b00010, 8'h00, "R12 add self");
      step(3'd3, 3'd0, 3'd0, 5'b00000, 8'h00, "R12 readback");
      chk("R12 doubled", 32'(mdl[3]), 32'h78);
      step(3'd1, 3'd0, 3'd1, 5'b00001, 8'h00, "R12 inc self");
      step(3'd1, 3'd0, 3'd0, 5'b00000, 8'h00, "R12 inc readback");
   endtask

   task automatic t_example();
      step(3'd0, 3'd0, 3'd2, 5'b00000, 8'h5A, "R2 setup");
      step(3'd0, 3'd0, 3'd3, 5'b00000, 8'h3C, "R2 setup");
      @(negedge clk);
      ctrl_word = 14'b010_011_001_00101;
      #1;
      chk("R2 example out", 32'(ext_out), 32'h1E);
      @(posedge clk);
      mdl[1] = 8'h1E;
      step(3'd1, 3'd0, 3'd0, 5'b00000, 8'h00, "R2 example R1");
   endtask

   task automatic t_reset();
      @(negedge clk);
      ctrl_word = {3'd1, 3'd0, 3'd0, 5'b00000};
      #1;
      chk("R1 out in reset", 32'(ext_out), 32'h0);
      read_all("R1 reset state");
   endtask

   initial begin
      #(CLK_P * 150000);
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int k = 1; k <= 7; k++) mdl[k] = '0;
      do_reset();
      t_reset();
      t_load();
      t_arith();
      t_logic();
      t_shift();
      t_nowrite();
      t_same_reg();
      t_undef();
      t_example();
      do_reset();
      t_reset();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule